// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block takes received frames from a byte stream and places each one into a memory buffer owned by a descriptor ring. When a frame starts, the engine reads the current descriptor. If hardware owns it, the engine streams the frame bytes into buffer 1 and then writes a completion word back into the descriptor. That word carries the frame length and the status flags, and it hands ownership back to software. The engine then moves to the next descriptor.

The stream carries a last-byte marker. Four status inputs are sampled with the last byte: CRC error, frame type, IP header checksum error and payload checksum error. A descriptor is four 32-bit words, laid out as follows:

- Word 0 holds the status and the ownership bit.
- Word 1 holds the control bits and the buffer size.
- Word 2 holds the buffer address.
- Word 3 holds the chained next-descriptor address.

The memory port allows one request at a time. It holds each request until the memory acknowledges it, and it addresses bytes with byte enables.

When the current descriptor belongs to software, the frame is consumed and dropped. A sticky buffer-unavailable flag is then set and a missed-frame counter advances. The descriptor is not skipped: the next frame fetches it again.

Top module: `rxwb_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs are idle: in_ready, mem_req, rx_int and rbu_flag are 0, and miss_cnt is 0.
- R2: When in_valid is seen while idle, the engine reads word 0 at the current descriptor address. If bit 31 is 1, it reads words 1, 2 and 3 at offsets 4, 8 and 12. Frame byte n is then written to address buf+n, where buf is word 2. Each byte write carries the byte on all four data lanes and sets the single byte enable numbered by address bits 1:0.
- R3: The completion write goes to word 0. In that word, bit 31 is 0, bits 29:16 hold the stored length, and both bit 9 (first) and bit 8 (last) are 1.
- R4: In the completion word, bit 1 is the CRC error, bit 5 the frame type, bit 7 the IP checksum error and bit 0 the payload checksum error. All four are taken with the last byte.
- R5: Bit 12 (length error) is 1 exactly when the frame has fewer than MIN_LEN bytes (default 64). A 64-byte frame does not set it.
- R6: The buffer size is word 1 bits 10:0. When a frame is longer than the buffer, the engine does the following:
  - it stores only the first size bytes and never writes beyond the buffer;
  - it reports size as the length;
  - it sets bit 11 (overflow);
  - it still closes the descriptor.
- R7: Bit 15 is the OR of the CRC error, length error, overflow and IP checksum error.
- R8: At most one memory request is outstanding. A request keeps its address and data until mem_ack. Word 0 is written only after every data write of the frame has been acknowledged.
- R9: The next descriptor is chosen as follows:
  - if word 1 bit 24 (chained) is set, word 3 is the next descriptor;
  - otherwise, if bit 25 (end of ring) is set, the next descriptor is ring_base;
  - otherwise it is the current address plus 16.
- R10: rx_int sets in the cycle after the completion write is acknowledged, unless word 1 bit 31 is set. stat_clr clears both rx_int and rbu_flag.
- R11: If word 0 bit 31 is 0, the following happens:
  - the frame is consumed to its last byte;
  - no memory request is made while it is dropped;
  - rbu_flag sets and miss_cnt increments by one;
  - the same descriptor is fetched again for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | First descriptor address, loaded at reset and used at end of ring |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of the frame |
| in_crc_err | input | 1 | CRC error status, valid with the last byte |
| in_frame_type | input | 1 | Frame type status, valid with the last byte |
| in_ip_err | input | 1 | IP header checksum error, valid with the last byte |
| in_pl_err | input | 1 | Payload checksum error, valid with the last byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rx_int | output | 1 | Sticky receive-complete interrupt |
| rbu_flag | output | 1 | Sticky buffer-unavailable status |
| stat_clr | input | 1 | Clears rx_int and rbu_flag |
| miss_cnt | output | MISS_W | Count of dropped frames |

## Verification
The assertions check the following on every cycle:

- a pending request stays stable until it is acknowledged;
- no byte write falls outside buffer 1;
- every completion write clears ownership and marks both segment flags;
- the bus stays quiet while a frame is dropped;
- the missed-frame count only steps by one;
- rx_int only rises after an acknowledged completion write.

Some behaviours only the bench scenarios can show:

- the exact status word for each frame;
- the truncated data and the untouched guard word after the buffer;
- the choice among the chained, end-of-ring and sequential next descriptor;
- the retry of a software-owned descriptor.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int LEN_W = 14;

  // word 0 bit positions
  localparam int B_OWN  = 31;
  localparam int B_LEN  = 16;
  localparam int B_ES   = 15;
  localparam int B_LE   = 12;
  localparam int B_OE   = 11;
  localparam int B_FIRST = 9;
  localparam int B_LAST = 8;
  localparam int B_ICE  = 7;
  localparam int B_FT   = 5;
  localparam int B_CE   = 1;
  localparam int B_PCE  = 0;

  // word 1 bit positions
  localparam int B_DIC   = 31;
  localparam int B_EOR   = 25;
  localparam int B_CHAIN = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3,
    S_DATA, S_WRB, S_CLOSE, S_WB, S_DROP
  } rx_state_e;

  typedef struct packed {
    logic crc;
    logic ftype;
    logic ip;
    logic pl;
  } rx_side_t;
endpackage

// File: rtl/rxwb_status.sv
module rxwb_status
  import rxwb_pkg::*;
#(
  parameter int BSIZE_W = 11,
  parameter int MIN_LEN = 64
) (
  input  logic [LEN_W-1:0]   cnt,
  input  logic [BSIZE_W-1:0] size,
  input  rx_side_t           side,
  output logic [31:0]        word
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] size_ext, stored;
  logic ovf, len_err, summary;

  always_comb begin
    size_ext = LEN_W'(size);
    ovf      = cnt > size_ext;
    stored   = ovf ? size_ext : cnt;
    len_err  = cnt < MIN_L;
    summary  = side.crc | len_err | ovf | side.ip;
    word              = '0;
    word[B_LEN +: LEN_W] = stored;
    word[B_ES]   = summary;
    word[B_LE]   = len_err;
    word[B_OE]   = ovf;
    word[B_FIRST] = 1'b1;
    word[B_LAST] = 1'b1;
    word[B_ICE]  = side.ip;
    word[B_FT]   = side.ftype;
    word[B_CE]   = side.crc;
    word[B_PCE]  = side.pl;
  end
endmodule

// File: rtl/rxwb_next.sv
module rxwb_next #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] link,
  input  logic [AW-1:0] base,
  input  logic          chained,
  input  logic          eor,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (chained)  nxt = link;
    else if (eor) nxt = base;
    else          nxt = cur + AW'(DESC_BYTES);
  end
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BSIZE_W    = 11,
  parameter int MIN_LEN    = 64,
  parameter int MISS_W     = 16,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_crc_err,
  input  logic              in_frame_type,
  input  logic              in_ip_err,
  input  logic              in_pl_err,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              rx_int,
  output logic              rbu_flag,
  input  logic              stat_clr,
  output logic [MISS_W-1:0] miss_cnt
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  rx_state_e          st;
  logic [AW-1:0]      desc_ptr, buf_addr, link_addr, next_ptr, byte_addr;
  logic [BSIZE_W-1:0] size;
  logic               dic, eor, chained, last_pend;
  logic [LEN_W-1:0]   cnt;
  rx_side_t           side;
  logic [31:0]        wb_word;

  rxwb_status #(.BSIZE_W(BSIZE_W), .MIN_LEN(MIN_LEN)) u_status (
    .cnt(cnt), .size(size), .side(side), .word(wb_word));

  rxwb_next #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_next (
    .cur(desc_ptr), .link(link_addr), .base(ring_base),
    .chained(chained), .eor(eor), .nxt(next_ptr));

  assign in_ready  = (st == S_DATA) || (st == S_DROP);
  assign byte_addr = buf_addr + AW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_be <= '0; mem_wdata <= '0;
      desc_ptr <= ring_base; buf_addr <= '0; link_addr <= '0;
      size <= '0; dic <= 1'b0; eor <= 1'b0; chained <= 1'b0;
      cnt <= '0; last_pend <= 1'b0; side <= '0;
      rx_int <= 1'b0; rbu_flag <= 1'b0; miss_cnt <= '0;
    end else begin
      if (stat_clr) begin
        rx_int   <= 1'b0;
        rbu_flag <= 1'b0;
      end
      case (st)
        S_IDLE: if (in_valid) begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_be <= 4'hF;
          mem_addr <= desc_ptr; st <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          if (mem_rdata[B_OWN]) begin
            mem_addr <= desc_ptr + AW'(4); st <= S_RD1;
          end else begin
            mem_req <= 1'b0; st <= S_DROP;
          end
        end
        S_RD1: if (mem_ack) begin
          dic <= mem_rdata[B_DIC]; eor <= mem_rdata[B_EOR];
          chained <= mem_rdata[B_CHAIN]; size <= mem_rdata[BSIZE_W-1:0];
          mem_addr <= desc_ptr + AW'(8); st <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          buf_addr <= mem_rdata[AW-1:0];
          mem_addr <= desc_ptr + AW'(12); st <= S_RD3;
        end
        S_RD3: if (mem_ack) begin
          link_addr <= mem_rdata[AW-1:0];
          mem_req <= 1'b0; cnt <= '0; st <= S_DATA;
        end
        S_DATA: if (in_valid) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          last_pend <= in_last;
          if (in_last) side <= '{crc: in_crc_err, ftype: in_frame_type,
                                 ip: in_ip_err, pl: in_pl_err};
          if (cnt < LEN_W'(size)) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= byte_addr;
            mem_be <= 4'b0001 << byte_addr[1:0];
            mem_wdata <= {4{in_data}}; st <= S_WRB;
          end else if (in_last) begin
            st <= S_CLOSE;
          end
        end
        S_WRB: if (mem_ack) begin
          mem_req <= 1'b0;
          st <= last_pend ? S_CLOSE : S_DATA;
        end
        S_CLOSE: begin
          mem_req <= 1'b1; mem_we <= 1'b1; mem_be <= 4'hF;
          mem_addr <= desc_ptr; mem_wdata <= wb_word; st <= S_WB;
        end
        S_WB: if (mem_ack) begin
          mem_req <= 1'b0; mem_we <= 1'b0;
          desc_ptr <= next_ptr;
          if (!dic) rx_int <= 1'b1;
          st <= S_IDLE;
        end
        S_DROP: if (in_valid && in_last) begin
          rbu_flag <= 1'b1;
          miss_cnt <= miss_cnt + 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R6
  buf_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WRB && mem_req) |-> ((mem_addr - buf_addr) < AW'(size)));

  // R3
  wb_word_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WB && mem_req) |-> (!mem_wdata[B_OWN] && mem_wdata[B_FIRST] && mem_wdata[B_LAST]));

  // R11
  drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DROP) |-> !mem_req);

  // R11
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt != $past(miss_cnt)) |-> (miss_cnt == $past(miss_cnt) + 1'b1));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_int) |-> $past(st == S_WB && mem_ack));
endmodule

// File: tb/test_rxwb_engine.sv
`timescale 1ns/1ps
module test_rxwb_engine;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] ring_base = 32'h100;
  logic in_valid = 0, in_last = 0, in_crc_err = 0, in_frame_type = 0, in_ip_err = 0, in_pl_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we, mem_ack = 0, rx_int, rbu_flag, stat_clr = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0] mem_be;
  logic [15:0] miss_cnt;
  logic [31:0] mem [0:1023];
  int checks = 0, errors = 0, cycles = 0;
  int data_seen = 0, exp_stored = 0;
  logic exp_int = 0, set_next = 0, run_mon = 0;

  always #2 clk = ~clk;

  rxwb_engine i_rxwb_engine (
    .clk(clk), .rst(rst), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_err(in_crc_err), .in_frame_type(in_frame_type),
    .in_ip_err(in_ip_err), .in_pl_err(in_pl_err), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_int(rx_int), .rbu_flag(rbu_flag), .stat_clr(stat_clr), .miss_cnt(miss_cnt));

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[11:2]][8*k +: 8] = mem_wdata[8*k +: 8];
      end else mem_rdata <= mem[mem_addr[11:2]];
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock reference for rx_int and completion ordering (R8, R10)
  always @(posedge clk) begin
    #1;
    if (run_mon) begin
      if (set_next) exp_int = 1'b1;
      set_next = 1'b0;
      if (stat_clr) exp_int = 1'b0;
      chk(rx_int == exp_int, "R10 rx_int per-clock", {31'b0, rx_int}, {31'b0, exp_int});
      if (mem_req && mem_we && mem_ack) begin
        if (mem_be == 4'hF) begin
          chk(data_seen == exp_stored, "R8 data writes before write-back", data_seen, exp_stored);
          if (!mem[(mem_addr[11:2]) + 1][31]) set_next = 1'b1;
          data_seen = 0;
        end else data_seen++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] expw(int total, int size, bit ce, bit ft, bit ice, bit pce);
    int stored = (total > size) ? size : total;
    bit ovf = total > size;
    bit le = total < 64;
    bit es = ce | le | ovf | ice;
    return (32'(stored) << 16) | (32'(es) << 15) | (32'(le) << 12) | (32'(ovf) << 11)
         | 32'h300 | (32'(ice) << 7) | (32'(ft) << 5) | (32'(ce) << 1) | 32'(pce);
  endfunction

  function automatic logic [7:0] rdbyte(int addr);
    return mem[addr >> 2][8*(addr & 3) +: 8];
  endfunction

  task automatic send(int len, logic [7:0] seed, bit ce, bit ft, bit ice, bit pce);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = seed + 8'(i); in_last = (i == len - 1);
      in_crc_err = ce; in_frame_type = ft; in_ip_err = ice; in_pl_err = pce;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic chk_buf(int base, int n, logic [7:0] seed, string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rdbyte(base + i) != seed + 8'(i)) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // descriptor at 0x100: chained to 0x140, buffer 0x200, size 100
    mem[32'h100 >> 2] = 32'h8000_0000; mem[32'h104 >> 2] = 32'h0100_0000 | 100;
    mem[32'h108 >> 2] = 32'h200;       mem[32'h10C >> 2] = 32'h140;
    // descriptor at 0x140: no interrupt, end of ring, buffer 0x300, size 64
    mem[32'h140 >> 2] = 32'h8000_0000; mem[32'h144 >> 2] = 32'h8200_0000 | 64;
    mem[32'h148 >> 2] = 32'h300;       mem[32'h14C >> 2] = 32'h0;
    mem[32'h340 >> 2] = 32'hDEAD_BEEF;

    repeat (3) @(negedge clk);
    chk(!in_ready && !mem_req && !rx_int && !rbu_flag && miss_cnt == 0, "R1 outputs in reset",
        {in_ready, mem_req, rx_int, rbu_flag}, 0);
    rst = 0;
    @(negedge clk);
    chk(!in_ready && !mem_req && !rx_int && miss_cnt == 0, "R1 outputs after reset",
        {in_ready, mem_req, rx_int}, 0);
    run_mon = 1;

    // frame A: 80 bytes, frame type set
    exp_stored = 80;
    send(80, 8'h10, 0, 1, 0, 0);
    chk(mem[32'h100 >> 2] == expw(80, 100, 0, 1, 0, 0), "R3 R4 word0 frame A", mem[32'h100 >> 2], expw(80, 100, 0, 1, 0, 0));
    chk_buf(32'h200, 80, 8'h10, "R2 buffer bytes frame A");
    chk(rx_int == 1, "R10 interrupt after frame A", rx_int, 1);

    pulse_clr();
    // frame B: 70 bytes into a 64-byte buffer, interrupt disabled
    exp_stored = 64;
    send(70, 8'h40, 0, 0, 0, 0);
    chk(mem[32'h140 >> 2] == expw(70, 64, 0, 0, 0, 0), "R6 R7 word0 truncated frame", mem[32'h140 >> 2], expw(70, 64, 0, 0, 0, 0));
    chk_buf(32'h300, 64, 8'h40, "R6 stored bytes truncated frame");
    chk(mem[32'h340 >> 2] == 32'hDEAD_BEEF, "R6 guard word after buffer", mem[32'h340 >> 2], 32'hDEAD_BEEF);
    chk(rx_int == 0, "R10 interrupt disabled", rx_int, 0);

    // frame C: end of ring returns to 0x100, now software owned -> dropped
    exp_stored = 0;
    send(30, 8'h90, 0, 0, 0, 0);
    chk(rbu_flag == 1, "R11 buffer unavailable set", rbu_flag, 1);
    chk(miss_cnt == 1, "R11 missed count", miss_cnt, 1);
    chk(mem[32'h200 >> 2] == 32'h1312_1110, "R11 buffer untouched", mem[32'h200 >> 2], 32'h1312_1110);
    chk(mem[32'h100 >> 2] == expw(80, 100, 0, 1, 0, 0), "R11 descriptor untouched", mem[32'h100 >> 2], expw(80, 100, 0, 1, 0, 0));

    // return descriptor 0x100 to hardware, sequential next this time
    mem[32'h100 >> 2] = 32'h8000_0000; mem[32'h104 >> 2] = 100;
    pulse_clr();
    chk(rbu_flag == 0, "R10 stat_clr clears buffer unavailable", rbu_flag, 0);
    // frame D: 40 bytes with errors; the same descriptor is refetched
    exp_stored = 40;
    send(40, 8'hA0, 1, 0, 1, 1);
    chk(mem[32'h100 >> 2] == expw(40, 100, 1, 0, 1, 1), "R4 R5 R7 word0 short errored frame", mem[32'h100 >> 2], expw(40, 100, 1, 0, 1, 1));
    chk_buf(32'h200, 40, 8'hA0, "R2 R11 refetched descriptor receives frame D");
    chk(rx_int == 1, "R10 interrupt frame D", rx_int, 1);

    // descriptor at 0x110 (current + 16), chained back to 0x100
    mem[32'h110 >> 2] = 32'h8000_0000; mem[32'h114 >> 2] = 32'h0100_0000 | 128;
    mem[32'h118 >> 2] = 32'h401;       mem[32'h11C >> 2] = 32'h100;
    exp_stored = 64;
    send(64, 8'h55, 0, 1, 0, 0);
    chk(mem[32'h110 >> 2] == expw(64, 128, 0, 1, 0, 0), "R9 R5 sequential descriptor, 64-byte frame", mem[32'h110 >> 2], expw(64, 128, 0, 1, 0, 0));
    chk_buf(32'h401, 64, 8'h55, "R2 unaligned buffer byte lanes");

    // frame F: chained back to 0x100, which software owns -> dropped
    exp_stored = 0;
    send(20, 8'h00, 0, 0, 0, 0);
    chk(miss_cnt == 2, "R9 R11 chained return to owned-by-software descriptor", miss_cnt, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule